// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Shadowed Compare Value

This block is a single channel of a timer. It is fed the free-running counter value and the update strobe from a shared timebase. It runs in one of two modes, chosen by one input.

**Output (compare) mode.** Software writes a compare value into a holding register. The channel compares an active copy of that value against the counter. It drives a registered reference level that is high while the counter is below the active value, which gives an up-counting PWM waveform. When shadowing is enabled, a new value waits in the holding register until the timebase signals an update. This lets a whole period finish on the old duty cycle.

**Input (capture) mode.** The channel synchronizes an external pin and detects its rising edges. On each rising edge it latches the counter into the same software-visible register. It also raises a capture flag, and an overrun flag when a capture arrives before the previous one was acknowledged.

Top module: `ccx_channel`

## Requirements
- R1: After synchronous reset, `rd_data_o`, `act_o`, `oc_ref_o`, `cap_flag_o` and `ovr_flag_o` are all zero.
- R2: In output mode (`mode_i`=0) with `pe_i`=0, a write (`wr_en_i`=1) loads `wr_data_i` into both the holding register (`rd_data_o`) and the active value (`act_o`) at the same clock edge.
- R3: In output mode with `pe_i`=1, a write changes only `rd_data_o`. `act_o` takes the holding value on the edge where `upd_i`=1. If a write and `upd_i` coincide, `act_o` receives the holding value from before that edge.
- R4: In output mode, `oc_ref_o` is 1 one clock after a cycle in which `cnt_i` < `act_o` (unsigned), and 0 otherwise. An active value of 0 keeps it low. An active value of 0xFFFF keeps it high except at a count of 0xFFFF.
- R5: Changing `pe_i` without a write or update leaves `act_o` unchanged.
- R6: In input mode (`mode_i`=1), a low-to-high change of `pin_i` stores `cnt_i` into `rd_data_o`. The stored value is the one present before the third rising clock edge at which `pin_i` is seen high. A falling edge stores nothing.
- R7: A capture sets `cap_flag_o`. A capture while `cap_flag_o` is already 1 also sets `ovr_flag_o`. `clr_i`=1 clears both flags on the next edge.
- R8: In input mode, writes do not change `rd_data_o`, `upd_i` does not change `act_o`, and `oc_ref_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = output compare, 1 = input capture |
| pe_i | input | 1 | Shadowing enable for the active compare value |
| cnt_i | input | W | Timebase counter value |
| upd_i | input | 1 | Update event strobe from the timebase |
| pin_i | input | 1 | Asynchronous capture input |
| wr_en_i | input | 1 | Write strobe for the compare value |
| wr_data_i | input | W | Write data |
| clr_i | input | 1 | Clear capture and overrun flags |
| rd_data_o | output | W | Holding register / captured value |
| act_o | output | W | Active compare value |
| oc_ref_o | output | 1 | Output compare reference level |
| cap_flag_o | output | 1 | Capture occurred |
| ovr_flag_o | output | 1 | Capture overrun |

## Verification
The assertions treat `mode_i` and `pe_i` as configuration levels. They expect `upd_i` and `wr_en_i` to be single-cycle strobes sampled at the clock. They relate register changes to the inputs of the preceding cycle.

The stimulus changes the mode only in cycles with no write, update or pin edge in flight. It holds `cnt_i` steady through each capture window so that the captured value is unambiguous. It moves `pin_i` only at falling clock edges.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

    localparam int unsigned CCX_W     = 16;
    localparam int unsigned CCX_SYNC  = 2;

    typedef enum logic {
        CCX_OUT = 1'b0,
        CCX_IN  = 1'b1
    } ccx_mode_e;

    typedef struct packed {
        logic cap;
        logic ovr;
    } ccx_flags_t;

    // Next state of the capture/overrun flags. A clear empties both flags;
    // a capture in the same cycle still marks the capture flag.
    function automatic ccx_flags_t ccx_flag_step(ccx_flags_t cur, logic hit, logic clr);
        ccx_flags_t nxt;
        if (clr) begin
            nxt.cap = hit;
            nxt.ovr = 1'b0;
        end else begin
            nxt.cap = cur.cap | hit;
            nxt.ovr = cur.ovr | (hit & cur.cap);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/ccx_insync.sv
module ccx_insync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic rise_o
);
    localparam int unsigned LEN = STAGES + 1;

    logic [LEN-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[LEN-2:0], d_i};
    end

    assign rise_o = sh[LEN-2] & ~sh[LEN-1];
endmodule

// File: rtl/ccx_regs.sv
module ccx_regs
    import ccx_pkg::*;
#(
    parameter int unsigned W = CCX_W
) (
    input  logic        clk,
    input  logic        rst,
    input  ccx_mode_e   mode,
    input  logic        pe,
    input  logic        upd,
    input  logic        wr_en,
    input  logic [W-1:0] wr_data,
    input  logic        cap_hit,
    input  logic [W-1:0] cap_val,
    input  logic        clr,
    output logic [W-1:0] shadow_o,
    output logic [W-1:0] active_o,
    output ccx_flags_t  flags_o
);
    logic [W-1:0] shadow_q, active_q;
    ccx_flags_t   flags_q;
    logic         hit_in;

    assign hit_in = (mode == CCX_IN) & cap_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            flags_q  <= '0;
        end else begin
            if (mode == CCX_OUT) begin
                if (wr_en) shadow_q <= wr_data;
                if (wr_en && !pe)      active_q <= wr_data;
                else if (pe && upd)    active_q <= shadow_q;
            end else if (hit_in) begin
                shadow_q <= cap_val;
            end
            flags_q <= ccx_flag_step(flags_q, hit_in, clr);
        end
    end

    assign shadow_o = shadow_q;
    assign active_o = active_q;
    assign flags_o  = flags_q;
endmodule

// File: rtl/ccx_ocmp.sv
module ccx_ocmp #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         ref_o
);
    logic ref_q;

    always_ff @(posedge clk) begin
        if (rst) ref_q <= 1'b0;
        else     ref_q <= en & (cnt < cmp);
    end

    assign ref_o = ref_q;
endmodule

// File: rtl/ccx_channel.sv
module ccx_channel
    import ccx_pkg::*;
#(
    parameter int unsigned W     = CCX_W,
    parameter int unsigned SYNCN = CCX_SYNC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_i,
    input  logic         pe_i,
    input  logic [W-1:0] cnt_i,
    input  logic         upd_i,
    input  logic         pin_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         clr_i,
    output logic [W-1:0] rd_data_o,
    output logic [W-1:0] act_o,
    output logic         oc_ref_o,
    output logic         cap_flag_o,
    output logic         ovr_flag_o
);
    ccx_mode_e  mode;
    logic       rise;
    ccx_flags_t flags;

    assign mode = ccx_mode_e'(mode_i);

    ccx_insync #(.STAGES(SYNCN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    (pin_i),
        .rise_o (rise)
    );

    ccx_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .pe       (pe_i),
        .upd      (upd_i),
        .wr_en    (wr_en_i),
        .wr_data  (wr_data_i),
        .cap_hit  (rise),
        .cap_val  (cnt_i),
        .clr      (clr_i),
        .shadow_o (rd_data_o),
        .active_o (act_o),
        .flags_o  (flags)
    );

    ccx_ocmp #(.W(W)) u_ocmp (
        .clk   (clk),
        .rst   (rst),
        .en    (mode == CCX_OUT),
        .cnt   (cnt_i),
        .cmp   (act_o),
        .ref_o (oc_ref_o)
    );

    assign cap_flag_o = flags.cap;
    assign ovr_flag_o = flags.ovr;
endmodule

// File: rtl/ccx_channel_chk.sv
module ccx_channel_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_i,
    input logic         pe_i,
    input logic [W-1:0] cnt_i,
    input logic         upd_i,
    input logic         wr_en_i,
    input logic [W-1:0] wr_data_i,
    input logic [W-1:0] rd_data_o,
    input logic [W-1:0] act_o,
    input logic         oc_ref_o,
    input logic         cap_flag_o,
    input logic         ovr_flag_o
);
    // R2: direct load of the active value without shadowing
    assert_direct_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !pe_i && wr_en_i) |=> act_o == $past(wr_data_i));

    // R3: update transfers the holding value
    assert_update_xfer_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && pe_i && upd_i) |=> act_o == $past(rd_data_o));

    // R5: no write and no update leaves the active value alone
    assert_active_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!upd_i && !wr_en_i) |=> $stable(act_o));

    // R4: reference level follows the previous comparison
    assert_ref_cmp_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_i) |=> oc_ref_o == ($past(cnt_i) < $past(act_o)));

    // R8: reference is low in capture mode
    assert_ref_low_in_R8: assert property (@(posedge clk) disable iff (rst)
        mode_i |=> !oc_ref_o);

    // R8: in capture mode the readable value only moves with a capture
    assert_no_write_in_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) && !$past(rst) && rd_data_o != $past(rd_data_o)) |-> cap_flag_o);

    // R7: an overrun never appears without a pending capture
    assert_ovr_after_cap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag_o) |-> ($past(cap_flag_o) && cap_flag_o));
endmodule

bind ccx_channel ccx_channel_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .pe_i       (pe_i),
    .cnt_i      (cnt_i),
    .upd_i      (upd_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .act_o      (act_o),
    .oc_ref_o   (oc_ref_o),
    .cap_flag_o (cap_flag_o),
    .ovr_flag_o (ovr_flag_o)
);

// File: tb/tb_ccx_channel.sv
module tb_ccx_channel;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         mode_i, pe_i, upd_i, pin_i, wr_en_i, clr_i;
    logic [W-1:0] cnt_i, wr_data_i;
    logic [W-1:0] rd_data_o, act_o;
    logic         oc_ref_o, cap_flag_o, ovr_flag_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ccx_channel dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .pe_i(pe_i), .cnt_i(cnt_i),
        .upd_i(upd_i), .pin_i(pin_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .clr_i(clr_i), .rd_data_o(rd_data_o), .act_o(act_o), .oc_ref_o(oc_ref_o),
        .cap_flag_o(cap_flag_o), .ovr_flag_o(ovr_flag_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [W-1:0] v);
        wr_en_i = 1'b1; wr_data_i = v;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic pulse_upd();
        upd_i = 1'b1;
        tick();
        upd_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] vals [6];
        logic [W-1:0] snap;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0007;
        vals[3] = 16'h8000; vals[4] = 16'hFFFE; vals[5] = 16'hFFFF;

        rst = 1'b1; mode_i = 1'b0; pe_i = 1'b0; upd_i = 1'b0; pin_i = 1'b0;
        wr_en_i = 1'b0; clr_i = 1'b0; cnt_i = '0; wr_data_i = '0;
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        chk(rd_data_o == 0, "R1 rd", rd_data_o, 0);
        chk(act_o == 0, "R1 act", act_o, 0);
        chk(!oc_ref_o && !cap_flag_o && !ovr_flag_o, "R1 flags",
            {oc_ref_o, cap_flag_o, ovr_flag_o}, 0);

        // R2: direct load
        wr(16'h1234);
        chk(rd_data_o == 16'h1234, "R2 rd", rd_data_o, 16'h1234);
        chk(act_o == 16'h1234, "R2 act", act_o, 16'h1234);

        // R4: sweep of compare values against counter values
        for (int a = 0; a < 6; a++) begin
            wr(vals[a]);
            for (int c = 0; c < 6; c++) begin
                cnt_i = vals[c];
                tick();
                chk(oc_ref_o == (vals[c] < vals[a]), "R4 edge", oc_ref_o, int'(vals[c] < vals[a]));
            end
        end
        wr(16'd150);
        for (int c = 0; c < 300; c++) begin
            cnt_i = W'(c);
            tick();
            chk(oc_ref_o == (c < 150), "R4 ramp", oc_ref_o, int'(c < 150));
        end

        // R3: shadowed writes
        wr(16'h00AA);
        pe_i = 1'b1;
        wr(16'h0BBB);
        chk(rd_data_o == 16'h0BBB, "R3 rd", rd_data_o, 16'h0BBB);
        chk(act_o == 16'h00AA, "R3 held", act_o, 16'h00AA);
        tick(); tick();
        chk(act_o == 16'h00AA, "R3 still held", act_o, 16'h00AA);
        pulse_upd();
        chk(act_o == 16'h0BBB, "R3 upd", act_o, 16'h0BBB);
        wr_en_i = 1'b1; wr_data_i = 16'h0CCC; upd_i = 1'b1;
        tick();
        wr_en_i = 1'b0; upd_i = 1'b0;
        chk(act_o == 16'h0BBB, "R3 same-cycle act", act_o, 16'h0BBB);
        chk(rd_data_o == 16'h0CCC, "R3 same-cycle rd", rd_data_o, 16'h0CCC);
        pulse_upd();
        chk(act_o == 16'h0CCC, "R3 second upd", act_o, 16'h0CCC);

        // R5: toggling the shadow enable alone
        wr(16'h0DDD);
        pe_i = 1'b0;
        tick(); tick();
        chk(act_o == 16'h0CCC, "R5 pe off", act_o, 16'h0CCC);
        pe_i = 1'b1;
        tick();
        chk(act_o == 16'h0CCC, "R5 pe on", act_o, 16'h0CCC);
        pe_i = 1'b0;
        wr(16'h0EEE);
        chk(act_o == 16'h0EEE, "R5 next write", act_o, 16'h0EEE);

        // R8: capture mode ignores writes and updates
        mode_i = 1'b1; cnt_i = '0;
        tick();
        chk(oc_ref_o == 1'b0, "R8 ref low", oc_ref_o, 0);
        snap = rd_data_o;
        wr(16'h7777);
        chk(rd_data_o == snap, "R8 write ignored", rd_data_o, snap);
        pe_i = 1'b1;
        pulse_upd();
        chk(act_o == 16'h0EEE, "R8 upd ignored", act_o, 16'h0EEE);

        // R6/R7: captures over a sweep of counter values
        for (int k = 0; k < 6; k++) begin
            cnt_i = vals[5 - k] ^ 16'h5A5A;
            snap = rd_data_o;
            pin_i = 1'b1;
            tick(); tick();
            chk(rd_data_o == snap, "R6 not yet", rd_data_o, snap);
            tick();
            chk(rd_data_o == (vals[5 - k] ^ 16'h5A5A), "R6 captured", rd_data_o, vals[5 - k] ^ 16'h5A5A);
            chk(cap_flag_o == 1'b1, "R7 cap flag", cap_flag_o, 1);
            chk(ovr_flag_o == (k != 0), "R7 ovr", ovr_flag_o, int'(k != 0));
            cnt_i = 16'h1111;
            pin_i = 1'b0;
            repeat (4) tick();
            chk(rd_data_o == (vals[5 - k] ^ 16'h5A5A), "R6 falling ignored", rd_data_o, vals[5 - k] ^ 16'h5A5A);
        end
        clr_i = 1'b1;
        tick();
        clr_i = 1'b0;
        chk(!cap_flag_o && !ovr_flag_o, "R7 clear", {cap_flag_o, ovr_flag_o}, 0);
        cnt_i = 16'h4321; pin_i = 1'b1;
        repeat (3) tick();
        chk(cap_flag_o && !ovr_flag_o, "R7 single", {cap_flag_o, ovr_flag_o}, 2);
        chk(rd_data_o == 16'h4321, "R6 after clear", rd_data_o, 16'h4321);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule